// File: doc/BRIEF.md
# Alias-Addressed Control Register Bank

This block is a bank of 32-bit control registers on a simple word-wide slave bus. Every register owns a 16-byte address window. The four word slots in that window are aliases of the same storage, and each alias applies its own update operation. Software can therefore set, clear or flip individual bits with one write and no read-modify-write sequence.

Two register groups sit inside a 64 KB window. The first is a clock-generator group at offset 0x60. It resets to fixed per-register defaults, and its control registers carry a lock-status bit that is always one. The second is a power-control group at offset 0x200, and it resets to zero. A read-only identification word at offset 0x800 takes priority over anything that overlaps it. Addresses that decode to nothing read as zero and ignore writes.

Reads are continuous. The bank registers the word selected by the address present at each clock edge.

Top module: `alias_bank`

## Requirements
- R1: Each register owns a 16-byte window. The register index is (address minus group base) shifted right by four. The clock group has 4 registers from 0x60 to 0x9F, and the power group has 4 registers from 0x200 to 0x23F. A write to one register leaves every other register unchanged.
- R2: A write at window offset 0x0 (address bits [3:2] = 00) replaces the register with the write data.
- R3: A write at window offset 0x4 (bits [3:2] = 01) ORs the write data into the register.
- R4: A write at window offset 0x8 (bits [3:2] = 10) clears the register bits that are one in the write data.
- R5: A write at window offset 0xC (bits [3:2] = 11) XORs the write data into the register.
- R6: A read at any of the four aliases returns the current register value. bus_rdata shows the word addressed at a clock edge, as it stood before any write at that same edge, and it is valid from that edge on. A write is therefore visible to a read presented in the next cycle.
- R7: Synchronous reset clears the power group to zero. It loads the clock group with 0x00002042, 0x0060302C, 0x06AAAC4D and 0x00000000 for registers 0 to 3, with the lock bits of R8 also set.
- R8: Bit 31 of clock-group registers 0 and 1 is a lock-status bit. It reads one after reset and stays one under every alias operation. Registers 2 and 3 have no such bit.
- R9: The word at 0x800 always reads 0x00720010. Writes to it have no effect, and it wins over any group that overlaps it.
- R10: Reads from addresses that decode to no register or identification word return zero, and writes to them change nothing.
- R11: An access whose address bits [1:0] are not 00 is not handled. Such a write changes nothing, and such a read returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Byte address within the 64 KB window |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address presented at the previous edge |

## Verification
A write takes effect at the clock edge where bus_we is high, and a read result appears one edge after its address is presented. Each bench task drives the inputs on the falling edge and lets exactly one rising edge pass before it samples bus_rdata on the next falling edge. The read-before-write case is checked by sampling bus_rdata after the very edge that performs the write, where the old value is expected. Every read that follows a write is started on a later cycle, so that it sees the updated register.

// File: rtl/alias_bank_pkg.sv
package alias_bank_pkg;

  // Update operation selected by address bits [3:2] inside a register window
  typedef enum logic [1:0] {
    OP_WRITE  = 2'b00,
    OP_SET    = 2'b01,
    OP_CLEAR  = 2'b10,
    OP_TOGGLE = 2'b11
  } alias_op_e;

  localparam int WINDOW_SHIFT = 4;   // 16-byte window per register

endpackage

// File: rtl/alias_window_decode.sv
module alias_window_decode
  import alias_bank_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BASE      = 'h60,
  parameter int REG_COUNT = 4,
  parameter int IDX_W     = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output alias_op_e         op
);

  localparam int SPAN = REG_COUNT << WINDOW_SHIFT;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(SPAN);

  logic [ADDR_W-1:0] rel;
  logic              aligned;

  always_comb begin
    rel     = addr - BASE_A;
    aligned = (addr[1:0] == 2'b00);
    hit     = aligned && (addr >= BASE_A) && (rel < SPAN_A);
    idx     = rel[IDX_W+WINDOW_SHIFT-1:WINDOW_SHIFT];
    op      = alias_op_e'(addr[3:2]);
  end

endmodule

// File: rtl/alias_op_apply.sv
module alias_op_apply
  import alias_bank_pkg::*;
#(
  parameter int              DATA_W = 32,
  parameter logic [DATA_W-1:0] STICKY = '0
) (
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] wdata,
  input  alias_op_e         op,
  output logic [DATA_W-1:0] nxt
);

  logic [DATA_W-1:0] raw;

  always_comb begin
    case (op)
      OP_WRITE:  raw = wdata;
      OP_SET:    raw = cur | wdata;
      OP_CLEAR:  raw = cur & ~wdata;
      OP_TOGGLE: raw = cur ^ wdata;
      default:   raw = cur;
    endcase
    nxt = raw | STICKY;   // sticky status bits cannot be removed
  end

endmodule

// File: rtl/alias_reg_group.sv
module alias_reg_group
  import alias_bank_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int REG_COUNT = 4,
  parameter int BASE      = 'h60,
  parameter logic [REG_COUNT*DATA_W-1:0] RESET_VALS = '0,
  parameter logic [REG_COUNT*DATA_W-1:0] STICKY_MASKS = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic              hit,
  output logic [DATA_W-1:0] rd_val
);

  localparam int IDX_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

  logic [IDX_W-1:0]  idx;
  alias_op_e         op;
  logic [DATA_W-1:0] regs_q [REG_COUNT];
  logic [REG_COUNT-1:0] wr_en;

  alias_window_decode #(
    .ADDR_W    (ADDR_W),
    .BASE      (BASE),
    .REG_COUNT (REG_COUNT),
    .IDX_W     (IDX_W)
  ) u_decode (
    .addr (addr),
    .hit  (hit),
    .idx  (idx),
    .op   (op)
  );

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_I    = RESET_VALS[i*DATA_W +: DATA_W];
    localparam logic [DATA_W-1:0] STICKY_I = STICKY_MASKS[i*DATA_W +: DATA_W];

    logic [DATA_W-1:0] nxt;

    assign wr_en[i] = we && hit && (idx == IDX_W'(i));

    alias_op_apply #(
      .DATA_W (DATA_W),
      .STICKY (STICKY_I)
    ) u_apply (
      .cur   (regs_q[i]),
      .wdata (wdata),
      .op    (op),
      .nxt   (nxt)
    );

    always_ff @(posedge clk) begin
      if (rst)          regs_q[i] <= RST_I | STICKY_I;
      else if (wr_en[i]) regs_q[i] <= nxt;
    end

    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !wr_en[i] |=> $stable(regs_q[i])); // R1

    AST_SET_KEEPS_ONES: assert property (@(posedge clk) disable iff (rst)
      (wr_en[i] && op == OP_SET) |=> ((regs_q[i] & $past(regs_q[i])) == $past(regs_q[i]))); // R3

    AST_CLEAR_DROPS_BITS: assert property (@(posedge clk) disable iff (rst)
      (wr_en[i] && op == OP_CLEAR) |=> ((regs_q[i] & $past(wdata) & ~STICKY_I) == '0)); // R4

    if (STICKY_I != '0) begin : g_lock
      AST_LOCK_HELD: assert property (@(posedge clk) disable iff (rst)
        (regs_q[i] & STICKY_I) == STICKY_I); // R8
    end
  end

  always_comb begin
    rd_val = '0;
    if (hit) rd_val = regs_q[idx];
  end

endmodule

// File: rtl/alias_bank.sv
module alias_bank #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int CLK_REGS  = 4,
  parameter int CLK_BASE  = 'h60,
  parameter int PWR_REGS  = 4,
  parameter int PWR_BASE  = 'h200,
  parameter int ID_OFFSET = 'h800,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h0072_0010,
  parameter int LOCK_BIT  = 31,
  parameter logic [CLK_REGS-1:0] CLK_LOCKED = 4'b0011,
  parameter logic [CLK_REGS*DATA_W-1:0] CLK_RESET =
    {32'h0000_0000, 32'h06AA_AC4D, 32'h0060_302C, 32'h0000_2042}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  function automatic logic [CLK_REGS*DATA_W-1:0] lock_masks();
    logic [CLK_REGS*DATA_W-1:0] v;
    v = '0;
    for (int i = 0; i < CLK_REGS; i++)
      if (CLK_LOCKED[i]) v[i*DATA_W + LOCK_BIT] = 1'b1;
    return v;
  endfunction

  localparam logic [CLK_REGS*DATA_W-1:0] CLK_STICKY = lock_masks();
  localparam logic [ADDR_W-1:0]          ID_A       = ADDR_W'(ID_OFFSET);

  logic              id_hit, clk_hit, pwr_hit, grp_we;
  logic [DATA_W-1:0] clk_val, pwr_val, rdata_d;

  // The identification overlay shadows everything at its address
  assign id_hit = (bus_addr == ID_A);
  assign grp_we = bus_we && !id_hit;

  alias_reg_group #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .REG_COUNT    (CLK_REGS),
    .BASE         (CLK_BASE),
    .RESET_VALS   (CLK_RESET),
    .STICKY_MASKS (CLK_STICKY)
  ) u_clk_group (
    .clk    (clk),
    .rst    (rst),
    .addr   (bus_addr),
    .we     (grp_we),
    .wdata  (bus_wdata),
    .hit    (clk_hit),
    .rd_val (clk_val)
  );

  alias_reg_group #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .REG_COUNT    (PWR_REGS),
    .BASE         (PWR_BASE),
    .RESET_VALS   ('0),
    .STICKY_MASKS ('0)
  ) u_pwr_group (
    .clk    (clk),
    .rst    (rst),
    .addr   (bus_addr),
    .we     (grp_we),
    .wdata  (bus_wdata),
    .hit    (pwr_hit),
    .rd_val (pwr_val)
  );

  always_comb begin
    if (id_hit)       rdata_d = ID_VALUE;
    else if (clk_hit) rdata_d = clk_val;
    else if (pwr_hit) rdata_d = pwr_val;
    else              rdata_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rdata_d;
  end

  AST_ID_READS_CONST: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ID_A) |=> (bus_rdata == ID_VALUE)); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!id_hit && !clk_hit && !pwr_hit) |=> (bus_rdata == '0)); // R10

  AST_GROUPS_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    !(clk_hit && pwr_hit)); // R1

endmodule

// File: tb/alias_bank_bench.sv
module alias_bank_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;   // 50 MHz

  alias_bank u_alias_bank (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_expect(input string req, input logic [15:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    check(req, bus_rdata, exp);
  endtask

  task automatic t_reset_state();
    rd_expect("R7/R8 clk reg0", 16'h0060, 32'h8000_2042);
    rd_expect("R7/R8 clk reg1", 16'h0070, 32'h8060_302C);
    rd_expect("R7 clk reg2",    16'h0080, 32'h06AA_AC4D);
    rd_expect("R7 clk reg3",    16'h0090, 32'h0000_0000);
    rd_expect("R7 pwr reg0",    16'h0200, 32'h0000_0000);
    rd_expect("R9 id word",     16'h0800, 32'h0072_0010);
  endtask

  task automatic t_alias_ops();
    wr(16'h0200, 32'h1234_5678);
    rd_expect("R2 overwrite", 16'h0200, 32'h1234_5678);
    rd_expect("R6 alias 0x4 read", 16'h0204, 32'h1234_5678);
    rd_expect("R6 alias 0x8 read", 16'h0208, 32'h1234_5678);
    rd_expect("R6 alias 0xC read", 16'h020C, 32'h1234_5678);
    wr(16'h0204, 32'h0000_000F);
    rd_expect("R3 set", 16'h0200, 32'h1234_567F);
    wr(16'h0208, 32'h0000_0070);
    rd_expect("R4 clear", 16'h0200, 32'h1234_560F);
    wr(16'h020C, 32'hFF00_FF00);
    rd_expect("R5 toggle", 16'h0200, 32'hED34_A90F);
  endtask

  task automatic t_decode();
    wr(16'h0230, 32'hA5A5_A5A5);
    rd_expect("R1 last pwr reg", 16'h023C, 32'hA5A5_A5A5);
    rd_expect("R1 neighbour intact", 16'h0200, 32'hED34_A90F);
    rd_expect("R1 clk reg3 intact", 16'h0090, 32'h0000_0000);
  endtask

  task automatic t_read_timing();
    // write and read the same address at one edge: old value returned
    @(negedge clk);
    bus_addr = 16'h0210; bus_we = 1'b1; bus_wdata = 32'h0000_0005;
    @(negedge clk);
    bus_we = 1'b0;
    check("R6 read before write", bus_rdata, 32'h0000_0000);
    @(negedge clk);
    check("R6 next-cycle read", bus_rdata, 32'h0000_0005);
  endtask

  task automatic t_lock();
    wr(16'h0068, 32'hFFFF_FFFF);
    rd_expect("R8 clear keeps lock", 16'h0060, 32'h8000_0000);
    wr(16'h006C, 32'h8000_0001);
    rd_expect("R8 toggle keeps lock", 16'h0060, 32'h8000_0001);
    wr(16'h0070, 32'h0000_0000);
    rd_expect("R8 overwrite keeps lock", 16'h0070, 32'h8000_0000);
    wr(16'h0088, 32'hFFFF_FFFF);
    rd_expect("R8 unlocked reg clears", 16'h0080, 32'h0000_0000);
    wr(16'h0094, 32'h8000_0000);
    rd_expect("R3 set on clk reg3", 16'h0090, 32'h8000_0000);
  endtask

  task automatic t_id_word();
    wr(16'h0800, 32'h0000_0000);
    rd_expect("R9 id after write", 16'h0800, 32'h0072_0010);
    rd_expect("R10 next to id", 16'h0804, 32'h0000_0000);
  endtask

  task automatic t_unmapped();
    wr(16'h0400, 32'hFFFF_FFFF);
    rd_expect("R10 unmapped read", 16'h0400, 32'h0000_0000);
    wr(16'h00A0, 32'hFFFF_FFFF);
    rd_expect("R10 past clk group", 16'h00A0, 32'h0000_0000);
    rd_expect("R10 pwr reg0 intact", 16'h0200, 32'hED34_A90F);
  endtask

  task automatic t_unaligned();
    wr(16'h0201, 32'h0000_0000);
    rd_expect("R11 write ignored", 16'h0200, 32'hED34_A90F);
    rd_expect("R11 read zero", 16'h0202, 32'h0000_0000);
    wr(16'h0063, 32'h0000_0000);
    rd_expect("R11 clk write ignored", 16'h0060, 32'h8000_0001);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got hang expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_alias_ops();
    t_decode();
    t_read_timing();
    t_lock();
    t_id_word();
    t_unmapped();
    t_unaligned();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule